// File: doc/BRIEF.md
# NAND Strobe Cycle Sequencer

This block drives the strobe waveforms for one byte-wide bus cycle on a NAND flash device: command, address or data, in either direction. A requester presents a direction, a cycle kind, a byte to write and two 32-bit timing words. The block latches them and waits for the device's ready line. It then steps through a fixed sequence of timed phases, each one a programmed number of clock ticks. At the end it returns the captured read byte and a one-clock completion pulse.

Each timing word carries four 8-bit tick counts. Software precomputes these counts from the device's datasheet timings and the controller clock, and the block uses them unchanged. Write cycles use the first word and read cycles use the second, except that read cycles also take their chip-enable setup count from the first word. Only one cycle is in flight at a time, so a requester issues the next cycle after it sees the completion pulse.

Top module: `nandStrobeSeq`

## Requirements
- R1: Out of reset, and whenever idle, `ceN`, `weN` and `reN` are high, `cle`, `ale`, `flashDataOe` and `done` are low.
- R2: Fields sit in byte lanes [31:24],[23:16],[15:8],[7:0]. `timingWrite` holds chip-enable setup, write extension, write cycle total, write-enable-high count. `timingRead` holds read access, read hold, read pulse, read release.
- R3: A write cycle has `weN` low for (cycle total − high count) ticks, or 1 tick if that is not positive. It then has `weN` high for the high count, then an extension of the write-extension count with the data bus released. `flashDataOe` is high, carrying the request byte, only during the first two phases.
- R4: A read cycle has `reN` high for the setup count, then low for the larger of access and pulse counts, then high for the hold count plus the release count, all with `ceN` low.
- R5: The read byte is taken from `flashDataIn` at the clock edge that ends the access-th tick of the `reN`-low phase. It is held on `rdData` from then on.
- R6: A field value of zero behaves as one tick.
- R7: After acceptance `ceN` goes low but no strobe falls while `rdyIn` is low. The first timed phase starts at the clock edge that samples `rdyIn` high.
- R8: After the last phase `done` is high for exactly one clock with `ceN`, `weN` and `reN` high. The block is idle the clock after.
- R9: `reqValid` is only honoured when idle. Changes to the request and timing inputs after acceptance do not alter the cycle in flight and do not start another.
- R10: Kind encoding: 2'b01 command raises `cle`, 2'b10 address raises `ale`, 2'b00 and 2'b11 are data and raise neither. `cle` and `ale` are only ever high while `ceN` is low.
- R11: `weN` and `reN` are never low together and are never low while `ceN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; one tick per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start a bus cycle (taken only when idle) |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqKind | input | 2 | Cycle kind: 01 command, 10 address, else data |
| reqWrData | input | 8 | Byte driven during a write cycle |
| timingWrite | input | 32 | Setup, write extension, write total, write-enable-high counts |
| timingRead | input | 32 | Access, hold, read pulse, release counts |
| rdyIn | input | 1 | Device ready (high) / busy (low) |
| flashDataIn | input | 8 | Byte returned by the device |
| ceN | output | 1 | Chip enable, active low |
| weN | output | 1 | Write enable, active low |
| reN | output | 1 | Read enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| flashDataOut | output | 8 | Byte to drive onto the device bus |
| flashDataOe | output | 1 | Output enable for `flashDataOut` |
| rdData | output | 8 | Last captured read byte |
| done | output | 1 | One-clock completion pulse |

## Verification
Some properties are checked on every clock by assertions. The two strobes stay exclusive and sit inside chip enable. The completion pulse is a single clock long with all strobes inactive. A falling write strobe always follows a sampled ready. The data bus is driven only inside a write cycle. The latch enables stay mutually exclusive. Other behaviour needs the bench's scenarios: the exact phase lengths produced by each field value, the zero-as-one rule, the clamp when the write total does not exceed the high count, the tick at which the read byte is sampled, and the immunity of an ongoing cycle to input changes. The bench measures these as lead, pulse and tail lengths of the chip-enable window. It also changes the device data every tick, so that the captured byte shows the exact tick at which it was sampled.

// File: rtl/nandStrobePkg.sv
package nandStrobePkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_WAITRDY,
    PH_WLOW,
    PH_WHIGH,
    PH_WEXT,
    PH_RSETUP,
    PH_RLOW,
    PH_RHOLD,
    PH_RREL,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic latch;    // take request and timing words
    logic capture;  // sample the device byte
    logic active;   // chip enable window
    logic drive;    // write byte on the bus
  } ctrlStrobes_t;

  // indices into the phase length vector
  localparam int LEN_WLOW   = 0;
  localparam int LEN_WHIGH  = 1;
  localparam int LEN_WEXT   = 2;
  localparam int LEN_RSETUP = 3;
  localparam int LEN_RLOW   = 4;
  localparam int LEN_RACC   = 5;
  localparam int LEN_RHOLD  = 6;
  localparam int LEN_RREL   = 7;
  localparam int LEN_COUNT  = 8;

endpackage

// File: rtl/nandStrobeDatapath.sv
module nandStrobeDatapath
  import nandStrobePkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 32,
  localparam int FIELD_W = WORD_W / 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobes_t                      strobes,
  input  logic                              reqWrite,
  input  logic [1:0]                        reqKind,
  input  logic [DATA_W-1:0]                 reqWrData,
  input  logic [WORD_W-1:0]                 timingWrite,
  input  logic [WORD_W-1:0]                 timingRead,
  input  logic [DATA_W-1:0]                 flashDataIn,
  output logic [LEN_COUNT-1:0][FIELD_W-1:0] lens,
  output logic                              isWrite,
  output logic                              cle,
  output logic                              ale,
  output logic [DATA_W-1:0]                 flashDataOut,
  output logic                              flashDataOe,
  output logic [DATA_W-1:0]                 rdData
);

  logic [WORD_W-1:0] wordW, wordR;
  logic [1:0]        kindQ;
  logic [DATA_W-1:0] byteQ, rdQ;
  logic              writeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordW  <= '0;
      wordR  <= '0;
      kindQ  <= '0;
      byteQ  <= '0;
      writeQ <= 1'b0;
    end else if (strobes.latch) begin
      wordW  <= timingWrite;
      wordR  <= timingRead;
      kindQ  <= reqKind;
      byteQ  <= reqWrData;
      writeQ <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '0;
    else if (strobes.capture) rdQ <= flashDataIn;
  end

  // lane 3 is the most significant byte lane
  logic [3:0][FIELD_W-1:0] laneW, laneR;
  for (genvar g = 0; g < 4; g++) begin : gLane
    assign laneW[g] = wordW[g*FIELD_W +: FIELD_W];
    assign laneR[g] = wordR[g*FIELD_W +: FIELD_W];
  end

  function automatic logic [FIELD_W-1:0] atLeastOne(input logic [FIELD_W-1:0] v);
    return (v == '0) ? FIELD_W'(1) : v;
  endfunction

  logic [FIELD_W-1:0] setupT, extT, totalT, highT;
  logic [FIELD_W-1:0] accT, holdT, pulseT, relT;
  logic [FIELD_W-1:0] accN, pulseN;

  assign setupT = laneW[3];
  assign extT   = laneW[2];
  assign totalT = laneW[1];
  assign highT  = laneW[0];
  assign accT   = laneR[3];
  assign holdT  = laneR[2];
  assign pulseT = laneR[1];
  assign relT   = laneR[0];

  assign accN   = atLeastOne(accT);
  assign pulseN = atLeastOne(pulseT);

  always_comb begin
    lens              = '0;
    lens[LEN_WLOW]    = (totalT > highT) ? (totalT - highT) : FIELD_W'(1);
    lens[LEN_WHIGH]   = atLeastOne(highT);
    lens[LEN_WEXT]    = atLeastOne(extT);
    lens[LEN_RSETUP]  = atLeastOne(setupT);
    lens[LEN_RACC]    = accN;
    lens[LEN_RLOW]    = (accN > pulseN) ? accN : pulseN;
    lens[LEN_RHOLD]   = atLeastOne(holdT);
    lens[LEN_RREL]    = atLeastOne(relT);
  end

  assign isWrite      = writeQ;
  assign cle          = strobes.active && (kindQ == 2'b01);
  assign ale          = strobes.active && (kindQ == 2'b10);
  assign flashDataOut = byteQ;
  assign flashDataOe  = strobes.drive;
  assign rdData       = rdQ;

endmodule

// File: rtl/nandStrobeControl.sv
module nandStrobeControl
  import nandStrobePkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              reqValid,
  input  logic                              rdyIn,
  input  logic                              isWrite,
  input  logic [LEN_COUNT-1:0][FIELD_W-1:0] lens,
  output ctrlStrobes_t                      strobes,
  output logic                              ceN,
  output logic                              weN,
  output logic                              reN,
  output logic                              done
);

  phase_e             phase, phaseNext;
  logic [FIELD_W-1:0] tick, curLen;
  logic               lastTick, timed;

  always_comb begin
    curLen = FIELD_W'(1);
    timed  = 1'b1;
    unique case (phase)
      PH_WLOW:   curLen = lens[LEN_WLOW];
      PH_WHIGH:  curLen = lens[LEN_WHIGH];
      PH_WEXT:   curLen = lens[LEN_WEXT];
      PH_RSETUP: curLen = lens[LEN_RSETUP];
      PH_RLOW:   curLen = lens[LEN_RLOW];
      PH_RHOLD:  curLen = lens[LEN_RHOLD];
      PH_RREL:   curLen = lens[LEN_RREL];
      default:   timed  = 1'b0;
    endcase
  end

  assign lastTick = timed && (tick == curLen);

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:    if (reqValid) phaseNext = PH_WAITRDY;
      PH_WAITRDY: if (rdyIn) phaseNext = isWrite ? PH_WLOW : PH_RSETUP;
      PH_WLOW:    if (lastTick) phaseNext = PH_WHIGH;
      PH_WHIGH:   if (lastTick) phaseNext = PH_WEXT;
      PH_WEXT:    if (lastTick) phaseNext = PH_DONE;
      PH_RSETUP:  if (lastTick) phaseNext = PH_RLOW;
      PH_RLOW:    if (lastTick) phaseNext = PH_RHOLD;
      PH_RHOLD:   if (lastTick) phaseNext = PH_RREL;
      PH_RREL:    if (lastTick) phaseNext = PH_DONE;
      PH_DONE:    phaseNext = PH_IDLE;
      default:    phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      tick  <= FIELD_W'(1);
    end else begin
      phase <= phaseNext;
      if (phaseNext != phase) tick <= FIELD_W'(1);
      else if (timed)         tick <= tick + FIELD_W'(1);
    end
  end

  always_comb begin
    strobes.latch   = (phase == PH_IDLE) && reqValid;
    strobes.capture = (phase == PH_RLOW) && (tick == lens[LEN_RACC]);
    strobes.active  = !(phase inside {PH_IDLE, PH_DONE});
    strobes.drive   = phase inside {PH_WLOW, PH_WHIGH};
  end

  assign ceN  = !strobes.active;
  assign weN  = (phase != PH_WLOW);
  assign reN  = (phase != PH_RLOW);
  assign done = (phase == PH_DONE);

endmodule

// File: rtl/nandStrobeSeq.sv
module nandStrobeSeq
  import nandStrobePkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 32,
  localparam int FIELD_W = WORD_W / 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqKind,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [WORD_W-1:0] timingWrite,
  input  logic [WORD_W-1:0] timingRead,
  input  logic              rdyIn,
  input  logic [DATA_W-1:0] flashDataIn,
  output logic              ceN,
  output logic              weN,
  output logic              reN,
  output logic              cle,
  output logic              ale,
  output logic [DATA_W-1:0] flashDataOut,
  output logic              flashDataOe,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);

  ctrlStrobes_t                      strobes;
  logic [LEN_COUNT-1:0][FIELD_W-1:0] lens;
  logic                              isWrite;

  nandStrobeControl #(.FIELD_W(FIELD_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .rdyIn   (rdyIn),
    .isWrite (isWrite),
    .lens    (lens),
    .strobes (strobes),
    .ceN     (ceN),
    .weN     (weN),
    .reN     (reN),
    .done    (done)
  );

  nandStrobeDatapath #(.DATA_W(DATA_W), .WORD_W(WORD_W)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqWrite    (reqWrite),
    .reqKind     (reqKind),
    .reqWrData   (reqWrData),
    .timingWrite (timingWrite),
    .timingRead  (timingRead),
    .flashDataIn (flashDataIn),
    .lens        (lens),
    .isWrite     (isWrite),
    .cle         (cle),
    .ale         (ale),
    .flashDataOut(flashDataOut),
    .flashDataOe (flashDataOe),
    .rdData      (rdData)
  );

endmodule

// File: rtl/nandStrobeSeqChecker.sv
module nandStrobeSeqChecker (
  input logic clk,
  input logic rstN,
  input logic rdyIn,
  input logic ceN,
  input logic weN,
  input logic reN,
  input logic cle,
  input logic ale,
  input logic flashDataOe,
  input logic done
);

  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !reN));

  assert_strobe_in_ce_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!weN || !reN) |-> !ceN);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ceN && weN && reN));

  assert_we_after_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weN) |-> $past(rdyIn));

  assert_oe_in_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    flashDataOe |-> (!ceN && reN));

  assert_latch_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));

  assert_latch_in_ce_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cle || ale) |-> !ceN);

endmodule

bind nandStrobeSeq nandStrobeSeqChecker uCheck (
  .clk        (clk),
  .rstN       (rstN),
  .rdyIn      (rdyIn),
  .ceN        (ceN),
  .weN        (weN),
  .reN        (reN),
  .cle        (cle),
  .ale        (ale),
  .flashDataOe(flashDataOe),
  .done       (done)
);

// File: tb/nandStrobeSeq_test.sv
module nandStrobeSeq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqKind = 2'b00;
  logic [7:0]  reqWrData = 8'h00;
  logic [31:0] timingWrite = 32'h0;
  logic [31:0] timingRead = 32'h0;
  logic        rdyIn = 1'b1;
  logic [7:0]  flashDataIn = 8'h00;
  logic        ceN, weN, reN, cle, ale, flashDataOe, done;
  logic [7:0]  flashDataOut, rdData;

  always #5 clk = ~clk;

  nandStrobeSeq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqKind(reqKind), .reqWrData(reqWrData), .timingWrite(timingWrite),
    .timingRead(timingRead), .rdyIn(rdyIn), .flashDataIn(flashDataIn),
    .ceN(ceN), .weN(weN), .reN(reN), .cle(cle), .ale(ale),
    .flashDataOut(flashDataOut), .flashDataOe(flashDataOe),
    .rdData(rdData), .done(done)
  );

  typedef struct {
    string      tag;
    bit         isWrite;
    int         lead, pulse, tail, oeCycles;
    logic [7:0] data;
    bit         expCle, expAle;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  logic [7:0] rdBase = 8'h00;
  bit finished = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int one(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // driver: computes the expected waveform and issues one request
  task automatic issue(input string tag, input bit wr, input logic [1:0] kind,
                       input logic [7:0] wb, input logic [31:0] tw,
                       input logic [31:0] tr, input int waitCycles);
    expItem_t e;
    int setupT = tw[31:24], extT = tw[23:16], totT = tw[15:8], highT = tw[7:0];
    int accT = tr[31:24], holdT = tr[23:16], pulT = tr[15:8], relT = tr[7:0];
    int acc;
    e.tag = tag;
    e.isWrite = wr;
    e.expCle = (kind == 2'b01);
    e.expAle = (kind == 2'b10);
    if (wr) begin
      e.lead = waitCycles;
      e.pulse = (totT > highT) ? totT - highT : 1;
      e.tail = one(highT) + one(extT);
      e.oeCycles = e.pulse + one(highT);
      e.data = wb;
    end else begin
      acc = one(accT);
      e.lead = waitCycles + one(setupT);
      e.pulse = (acc > one(pulT)) ? acc : one(pulT);
      e.tail = one(holdT) + one(relT);
      e.oeCycles = 0;
      e.data = rdBase + 8'(acc);
    end
    expQ.push_back(e);
    @(negedge clk);
    reqWrite = wr; reqKind = kind; reqWrData = wb;
    timingWrite = tw; timingRead = tr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone();
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: measures each chip-enable window and scores it at done
  initial begin : monitor
    int lead = 0, pulse = 0, tail = 0, oeC = 0;
    bit seen = 0, dataBad = 0, cleS = 0, aleS = 0, prevDone = 0;
    expItem_t e;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (!weN && !reN) check(0, "R11 both strobes low", 1, 0);
        if (!ceN) begin
          if (!weN || !reN) begin
            pulse++;
            if (!seen) begin cleS = cle; aleS = ale; end
            seen = 1;
          end else if (!seen) lead++;
          else tail++;
          if (flashDataOe) begin
            oeC++;
            if (expQ.size() > 0 && flashDataOut !== expQ[0].data) dataBad = 1;
          end
        end
        if (!reN) flashDataIn = rdBase + 8'(pulse);
        if (done) begin
          check(!prevDone, "R8 done longer than one clock", 1, 0);
          check(ceN && weN && reN, "R8 strobes active with done", {ceN, weN, reN}, 7);
          if (expQ.size() == 0) check(0, "R9 unexpected cycle", 1, 0);
          else begin
            e = expQ.pop_front();
            check(lead == e.lead, {e.tag, " lead ticks"}, lead, e.lead);
            check(pulse == e.pulse, {e.tag, " strobe low ticks"}, pulse, e.pulse);
            check(tail == e.tail, {e.tag, " tail ticks"}, tail, e.tail);
            check(oeC == e.oeCycles, {e.tag, " R3 bus drive ticks"}, oeC, e.oeCycles);
            check(cleS == e.expCle && aleS == e.expAle, {e.tag, " R10 cle/ale"},
                  {cleS, aleS}, {e.expCle, e.expAle});
            if (e.isWrite) check(!dataBad, {e.tag, " R3 write byte"}, dataBad, 0);
            else check(rdData === e.data, {e.tag, " R5 read byte"}, rdData, e.data);
          end
          lead = 0; pulse = 0; tail = 0; oeC = 0; seen = 0; dataBad = 0;
        end
        prevDone = done;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ceN && weN && reN && !done && !cle && !ale && !flashDataOe,
          "R1 reset state", {ceN, weN, reN, done}, 4'b1110);

    // command write, distinct fields: setup 2, ext 3, total 5, high 2
    issue("R3 R2 cmd write", 1, 2'b01, 8'hA5, 32'h02_03_05_02, 32'h0, 1);
    waitDone();
    check(ceN && weN && reN && !done, "R1 idle after cycle", {ceN, weN, reN, done}, 4'b1110);

    // address write where total does not exceed high count
    issue("R3 clamp addr write", 1, 2'b10, 8'h3C, 32'h01_01_02_04, 32'h0, 1);
    waitDone();

    // data read: setup 2, access 4, hold 2, pulse 6, release 3
    rdBase = 8'h40;
    issue("R4 R2 read pulse-long", 0, 2'b00, 8'h00, 32'h02_00_00_00, 32'h04_02_06_03, 1);
    waitDone();

    // read with access longer than pulse
    rdBase = 8'h80;
    issue("R5 read access-long", 0, 2'b11, 8'h00, 32'h01_00_00_00, 32'h07_01_03_01, 1);
    waitDone();

    // all zero fields
    issue("R6 zero write", 1, 2'b00, 8'h5A, 32'h0, 32'h0, 1);
    waitDone();
    rdBase = 8'h10;
    issue("R6 zero read", 0, 2'b01, 8'h00, 32'h0, 32'h0, 1);
    waitDone();

    // ready held low after acceptance
    rdyIn = 1'b0;
    issue("R7 wait write", 1, 2'b00, 8'hC3, 32'h00_01_03_01, 32'h0, 6);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(weN && reN && !ceN, "R7 no strobe while busy", {ceN, weN, reN}, 3'b011);
    end
    rdyIn = 1'b1;
    waitDone();

    // new request and timing changes during a cycle
    rdBase = 8'h20;
    issue("R9 read under noise", 0, 2'b10, 8'h00, 32'h03_00_00_00, 32'h05_04_05_04, 1);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqKind = 2'b01;
    timingWrite = 32'hFF_FF_FF_FF; timingRead = 32'h01_01_01_01;
    @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    waitDone();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(ceN && weN && reN, "R9 no extra cycle", {ceN, weN, reN}, 3'b111);
    end
    check(expQ.size() == 0, "R9 scoreboard drained", expQ.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule